// File: doc/BRIEF.md
# Bus Arbiter With Processor Rotation

This block decides which of six requesters owns a shared bus: four initiators, one extra peripheral requester and the host processor. Each requester raises its line in `req`, and the block answers with a registered one-hot grant on `gnt`. A `frame_active` input tells the block when a transfer is in progress. The arbiter uses it to find the end of a frame and to measure idle time.

The priority scheme is set by configuration inputs. It can be fixed priority or fair round-robin. Re-arbitration can happen only when the owner releases its request, or also at the end of each frame, which lets a more urgent initiator pre-empt the owner. A rotation field can force a grant to the processor after every one, two or three non-processor grants. An idle timeout in units of 32 bus clocks can take the bus away from an owner that keeps its request raised but does no transfers.

The grant can only move at an arbitration point. An arbitration point is one of three events: the owner's request is low, the idle timeout expires, or frame-end re-arbitration is enabled and `frame_active` falls. At such a point the block reloads its stored frame-end mode and timeout field from the configuration inputs. The priority, round-robin and rotation inputs are only read at these points. When nobody requests, the grant parks on the processor.

Top module: `bus_arbiter_rot`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `gnt` equals 6'b100000 (processor). The stored frame-end mode and timeout field clear to zero, and the rotation count clears to zero.
- R2: Requester index 0..3 are initiators, 4 is the peripheral and 5 is the processor. In fixed mode (`cfg_rr`=0), an arbitration point grants the lowest-numbered requesting index.
- R3: In round-robin mode (`cfg_rr`=1), the search starts at the index after the last requester that won, wraps from 5 back to 0, and grants the first requester found. After reset the last winner is index 5.
- R4: When the stored frame-end mode is 0, `gnt` holds while the owner's request stays high and no timeout expires, even if a higher-priority request appears.
- R5: When the stored frame-end mode is 1, a falling edge of `frame_active` is also an arbitration point, so a higher-priority requester takes the bus from the current owner.
- R6: When the stored timeout field N is nonzero, N*32 consecutive cycles with `frame_active` low and no other arbitration point force an arbitration. That arbitration excludes the current owner whenever any other requester is waiting. N=0 disables the timeout.
- R7: A rotation count tracks how many non-processor grants have been made since the processor was last granted. It saturates at 3. With `cfg_rot_en`=1 and `cfg_rot`=K in 1..3, once the count has reached K, the next arbitration point grants the processor if `req[5]` is high. With `cfg_rot_en`=0 or K=0, no grant is forced.
- R8: `gnt` is always exactly one-hot.
- R9: Changes on the configuration inputs have no effect on `gnt` between arbitration points.
- R10: An arbitration point with no request raised parks `gnt` on the processor (6'b100000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 6 | Request lines; 0-3 initiators, 4 peripheral, 5 processor |
| frame_active | input | 1 | High while a bus transfer frame is in progress |
| cfg_rr | input | 1 | 1 = round-robin, 0 = fixed priority |
| cfg_frame_arb | input | 1 | 1 = also re-arbitrate at each frame end |
| cfg_idle | input | 4 | Idle timeout in units of 32 clocks; 0 disables |
| cfg_rot_en | input | 1 | Enables forced processor rotation |
| cfg_rot | input | 2 | Non-processor grants between forced processor grants |
| gnt | output | 6 | One-hot registered grant |

## Verification
The hard corners are the interactions between events. A frame end that arrives before the stored mode has switched must not move the grant; a design that reads the mode input directly would pre-empt one arbitration too early. The timeout must fire on exactly the 32nd idle cycle and must hand the bus to someone other than the owner; an off-by-one counter, or a design that does not exclude the owner, shows up as a grant that moves one cycle late or never moves. Rotation must override fixed priority only after the configured count, and the round-robin pointer must wrap from the processor back to initiator 0. Long random runs compare every cycle's grant against a bench model, so any misordered priority or skipped arbitration point is seen at once.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NREQ    = 6;
    localparam int CPU_IDX = NREQ - 1;
    localparam int IDX_W   = $clog2(NREQ);
    localparam int IDLE_W  = 4;
    localparam int ROT_W   = 2;

    typedef logic [NREQ-1:0]  req_vec_t;
    typedef logic [IDX_W-1:0] idx_t;

    // configuration that is captured only at arbitration points
    typedef struct packed {
        logic              frame_arb;
        logic [IDLE_W-1:0] idle;
    } held_cfg_t;

    function automatic req_vec_t to_onehot(idx_t i);
        return req_vec_t'(1) << i;
    endfunction

    // lowest index wins; no request yields the processor
    function automatic idx_t pick_fixed(req_vec_t r);
        idx_t p;
        p = idx_t'(CPU_IDX);
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (r[i]) p = idx_t'(i);
        end
        return p;
    endfunction

    // search starts after the previous winner and wraps
    function automatic idx_t pick_rr(req_vec_t r, idx_t last);
        idx_t p;
        logic hit;
        int   j;
        p   = last;
        hit = 1'b0;
        for (int k = 1; k <= NREQ; k++) begin
            j = (int'(last) + k) % NREQ;
            if (!hit && r[j]) begin
                p   = idx_t'(j);
                hit = 1'b1;
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/arb_idle_timer.sv
module arb_idle_timer #(
    parameter int UNIT  = 32,
    parameter int FLD_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_active,
    input  logic             clear,
    input  logic [FLD_W-1:0] fld,
    output logic             tout
);
    localparam int MAXC = UNIT * ((1 << FLD_W) - 1);
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = CW'(fld) * CW'(UNIT);
    assign tout = (fld != '0) && !frame_active && (cnt == lim - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || frame_active || clear)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/arb_rotation.sv
module arb_rotation
    import arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             point,
    input  idx_t             win_idx,
    input  logic             win_valid,
    input  logic             rot_en,
    input  logic [ROT_W-1:0] rot,
    output logic             rot_due
);
    logic [ROT_W-1:0] rc;

    assign rot_due = rot_en && (rot != '0) && (rc >= rot);

    always_ff @(posedge clk) begin
        if (rst)
            rc <= '0;
        else if (point) begin
            if (win_idx == idx_t'(CPU_IDX))
                rc <= '0;
            else if (win_valid && (rc != '1))
                rc <= rc + ROT_W'(1);
        end
    end
endmodule

// File: rtl/arb_select.sv
module arb_select
    import arb_pkg::*;
(
    input  req_vec_t cand,
    input  logic     rr_mode,
    input  idx_t     last,
    input  logic     force_cpu,
    output idx_t     winner
);
    always_comb begin
        if (force_cpu)
            winner = idx_t'(CPU_IDX);
        else if (rr_mode)
            winner = pick_rr(cand, last);
        else
            winner = pick_fixed(cand);
    end
endmodule

// File: rtl/bus_arbiter_rot.sv
module bus_arbiter_rot
    import arb_pkg::*;
#(
    parameter int IDLE_UNIT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NREQ-1:0]   req,
    input  logic              frame_active,
    input  logic              cfg_rr,
    input  logic              cfg_frame_arb,
    input  logic [IDLE_W-1:0] cfg_idle,
    input  logic              cfg_rot_en,
    input  logic [ROT_W-1:0]  cfg_rot,
    output logic [NREQ-1:0]   gnt
);
    req_vec_t  gnt_q;
    held_cfg_t cfg_act;
    logic      frame_q;
    idx_t      last_q;

    logic      owner_drop, frame_end, tout, arb_point;
    logic      rot_due, rot_force, cand_any;
    req_vec_t  others, cand;
    idx_t      winner, win_idx;

    assign owner_drop = (gnt_q & req) == '0;
    assign frame_end  = frame_q && !frame_active;
    assign arb_point  = owner_drop || tout || (cfg_act.frame_arb && frame_end);
    assign others     = req & ~gnt_q;
    assign cand       = (tout && (others != '0)) ? others : req;
    assign cand_any   = cand != '0;
    assign rot_force  = rot_due && req[CPU_IDX];
    assign win_idx    = cand_any ? winner : idx_t'(CPU_IDX);

    arb_idle_timer #(.UNIT(IDLE_UNIT), .FLD_W(IDLE_W)) u_timer (
        .clk(clk), .rst(rst), .frame_active(frame_active),
        .clear(arb_point), .fld(cfg_act.idle), .tout(tout)
    );

    arb_rotation u_rot (
        .clk(clk), .rst(rst), .point(arb_point), .win_idx(win_idx),
        .win_valid(cand_any), .rot_en(cfg_rot_en), .rot(cfg_rot),
        .rot_due(rot_due)
    );

    arb_select u_sel (
        .cand(cand), .rr_mode(cfg_rr), .last(last_q),
        .force_cpu(rot_force), .winner(winner)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q   <= to_onehot(idx_t'(CPU_IDX));
            cfg_act <= '0;
            frame_q <= 1'b0;
            last_q  <= idx_t'(CPU_IDX);
        end else begin
            frame_q <= frame_active;
            if (arb_point) begin
                gnt_q             <= to_onehot(win_idx);
                cfg_act.frame_arb <= cfg_frame_arb;
                cfg_act.idle      <= cfg_idle;
                if (cand_any) last_q <= winner;
            end
        end
    end

    assign gnt = gnt_q;
endmodule

// File: rtl/arb_rot_chk.sv
module arb_rot_chk
    import arb_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NREQ-1:0] req,
    input logic [NREQ-1:0] gnt,
    input logic            arb_point,
    input logic            tout,
    input logic            rot_force,
    input logic            act_frame_arb,
    input logic            cfg_rr
);
    // R1
    reset_park_chk: assert property (@(posedge clk)
        rst |=> (gnt == to_onehot(idx_t'(CPU_IDX))));

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(gnt) == 1);

    // R4
    owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!act_frame_arb && ((gnt & req) != '0) && !tout) |=> $stable(gnt));

    // R10
    idle_park_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> gnt[CPU_IDX]);

    // R2
    top_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (arb_point && !cfg_rr && req[0] && !rot_force && !tout) |=> gnt[0]);
endmodule

bind bus_arbiter_rot arb_rot_chk u_chk (
    .clk(clk), .rst(rst), .req(req), .gnt(gnt),
    .arb_point(arb_point), .tout(tout), .rot_force(rot_force),
    .act_frame_arb(cfg_act.frame_arb), .cfg_rr(cfg_rr)
);

// File: tb/sim_bus_arbiter_rot.sv
`timescale 1ns/1ps
module sim_bus_arbiter_rot;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] req = '0;
    logic       frame_active = 1'b0;
    logic       cfg_rr = 1'b0, cfg_frame_arb = 1'b0, cfg_rot_en = 1'b0;
    logic [3:0] cfg_idle = '0;
    logic [1:0] cfg_rot = '0;
    logic [5:0] gnt;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    bus_arbiter_rot u0 (
        .clk(clk), .rst(rst), .req(req), .frame_active(frame_active),
        .cfg_rr(cfg_rr), .cfg_frame_arb(cfg_frame_arb), .cfg_idle(cfg_idle),
        .cfg_rot_en(cfg_rot_en), .cfg_rot(cfg_rot), .gnt(gnt)
    );

    // bench model state
    int    m_g, m_last, m_rc, m_cnt;
    bit    m_fq, m_afa;
    int    m_aidle;
    string m_tag;

    function automatic int f_fixed(logic [5:0] r);
        for (int i = 0; i < 6; i++) if (r[i]) return i;
        return 5;
    endfunction

    function automatic int f_rr(logic [5:0] r, int last);
        for (int k = 1; k <= 6; k++) if (r[(last + k) % 6]) return (last + k) % 6;
        return last;
    endfunction

    task automatic model_step();
        logic [5:0] gv, others, cand;
        bit drop, fend, tout, point, frc;
        int w;
        if (rst) begin
            m_g = 5; m_last = 5; m_rc = 0; m_cnt = 0;
            m_fq = 0; m_afa = 0; m_aidle = 0; m_tag = "R1";
            return;
        end
        gv    = 6'b1 << m_g;
        drop  = (gv & req) == 0;
        fend  = m_fq && !frame_active;
        tout  = (m_aidle != 0) && !frame_active && (m_cnt == m_aidle * 32 - 1);
        point = drop || tout || (m_afa && fend);
        m_tag = "R4";
        if (point) begin
            others = req & ~gv;
            cand   = (tout && others != 0) ? others : req;
            frc    = cfg_rot_en && (cfg_rot != 0) && (m_rc >= int'(cfg_rot)) && req[5];
            if (cand == 0) begin
                w = 5; m_tag = "R10";
            end else begin
                if (frc) begin w = 5; m_tag = "R7"; end
                else begin
                    w = cfg_rr ? f_rr(cand, m_last) : f_fixed(cand);
                    if (tout) m_tag = "R6";
                    else if (!drop) m_tag = "R5";
                    else m_tag = cfg_rr ? "R3" : "R2";
                end
                m_last = w;
            end
            if (w == 5) m_rc = 0;
            else if (m_rc < 3) m_rc++;
            m_g = w; m_afa = cfg_frame_arb; m_aidle = int'(cfg_idle);
        end
        m_cnt = (frame_active || point) ? 0 : m_cnt + 1;
        m_fq  = frame_active;
    endtask

    task automatic check(logic [5:0] act, logic [5:0] exp, string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt=%b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // one clock: model advances with current inputs, grant checked after the edge
    task automatic tick();
        model_step();
        @(negedge clk);
        cycles++;
        check(gnt, 6'b1 << m_g, m_tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        check(gnt, 6'b100000, "R1");
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [5:0] r;
        bit quiet;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R10: nothing requested, park on processor
        req = 6'b000000; tick(); check(gnt, 6'b100000, "R10");
        // R2: fixed priority picks lowest index
        req = 6'b001110; tick(); check(gnt, 6'b000010, "R2");
        // R4: higher request does not pre-empt in drop mode
        req = 6'b001111;
        repeat (3) tick();
        check(gnt, 6'b000010, "R4");
        // R9: frame-end mode written mid-grant has no effect yet
        cfg_frame_arb = 1'b1; frame_active = 1'b1; tick();
        frame_active = 1'b0; tick(); check(gnt, 6'b000010, "R9");
        // owner drops: arbitration point loads frame-end mode
        req = 6'b001101; tick(); check(gnt, 6'b000001, "R2");
        req = 6'b001100; tick(); check(gnt, 6'b000100, "R2");
        req = 6'b001101; frame_active = 1'b1; tick(); check(gnt, 6'b000100, "R4");
        // R5: frame end lets index 0 pre-empt
        frame_active = 1'b0; tick(); check(gnt, 6'b000001, "R5");

        // R3: round-robin walk with wrap
        cfg_rr = 1'b1; cfg_frame_arb = 1'b0;
        req = 6'b001110; tick(); check(gnt, 6'b000010, "R3");
        req = 6'b001101; tick(); check(gnt, 6'b000100, "R3");
        req = 6'b001011; tick(); check(gnt, 6'b001000, "R3");
        req = 6'b000011; tick(); check(gnt, 6'b000001, "R3");

        // R7: processor forced after two initiator grants
        cfg_rr = 1'b0; cfg_rot_en = 1'b1; cfg_rot = 2'd2;
        do_reset();
        req = 6'b000011; tick(); check(gnt, 6'b000001, "R7");
        req = 6'b100010; tick(); check(gnt, 6'b000010, "R7");
        req = 6'b100001; tick(); check(gnt, 6'b100000, "R7");
        req = 6'b000001; tick(); check(gnt, 6'b000001, "R7");
        cfg_rot_en = 1'b0; cfg_rot = 2'd0;

        // R6: 32 idle cycles force the bus away from the owner
        cfg_idle = 4'd1;
        do_reset();
        req = 6'b000011; tick(); check(gnt, 6'b000001, "R6");
        repeat (31) tick();
        check(gnt, 6'b000001, "R6");
        tick(); check(gnt, 6'b000010, "R6");
        // R6: zero disables the timeout
        cfg_idle = 4'd0;
        req = 6'b000001; tick(); check(gnt, 6'b000001, "R6");
        req = 6'b000011;
        repeat (100) tick();
        check(gnt, 6'b000001, "R6");

        // random phases checked every cycle against the model (R2-R10)
        do_reset();
        for (int blk = 0; blk < 40; blk++) begin
            cfg_rr        = 1'($urandom_range(0, 1));
            cfg_frame_arb = 1'($urandom_range(0, 1));
            cfg_idle      = 4'($urandom_range(0, 2));
            cfg_rot_en    = 1'($urandom_range(0, 1));
            cfg_rot       = 2'($urandom_range(0, 3));
            quiet         = ($urandom_range(0, 2) == 0);
            for (int c = 0; c < 150; c++) begin
                r = req;
                for (int b = 0; b < 6; b++)
                    if ($urandom_range(0, 7) == 0) r[b] = ~r[b];
                req = r;
                if (quiet) frame_active = 1'b0;
                else if ($urandom_range(0, 3) == 0) frame_active = ~frame_active;
                if ($urandom_range(0, 60) == 0) cfg_rr = ~cfg_rr;
                tick();
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule